// File: doc/BRIEF.md
# Flash Controller Command and Lock Unit

This unit fronts an on-chip flash array with three 32-bit registers on a simple write/read bus: a key register, a status register and a control register. Software must write two fixed key words, in order, to the key register. Until it does, the control register cannot be changed and the array cannot be programmed. A wrong key word locks the unit until the next reset.

Once the unit is unlocked, a control write with the start bit launches one of two erases: a single numbered sector or the whole array. With program enable set, a data write on the array port launches a program operation of the selected width. Each launched operation appears as a one-cycle command on the array-side outputs. The command carries the kind, the byte base and length, and the data. A parameterised cycle counter then holds the busy flag for as long as the array operation would take. Rejected requests launch nothing and raise a sticky error flag. Software clears each flag by writing a one to its bit.

Top module: `flashctl_unit`

## Requirements
- R1: Registers sit at byte offsets key 0x04, status 0x0C and control 0x10. After reset the control register reads 0x8000_0000 and the status register reads 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB as consecutive key-register writes clears control bit 31 (the lock bit).
- R3: A key write of the wrong value, or the keys in the wrong order, leaves the unit locked until reset. Every later key write is then ignored. After a reset the correct sequence unlocks again.
- R4: While the unit is locked, control writes are ignored. Writing control with bit 31 set relocks the unit, and the two keys are needed again.
- R5: Control fields read back as written: program enable at bit 0, sector erase at bit 1, mass erase at bit 2, sector number at bits 6:3 and program size at bits 9:8. The start bit (bit 16) always reads 0.
- R6: A control write with sector erase, a sector number from 0 to 11 and start emits one command with kind 1. Its base and length follow the layout: sectors 0 to 3 are 16 KiB each, sector 4 is 64 KiB and sectors 5 to 11 are 128 KiB each, placed from offset 0. Busy (status bit 16) is then high for T_SECT cycles.
- R7: A control write with mass erase and start emits one command with kind 2, base 0 and length 0x100000. Busy is then high for T_MASS cycles.
- R8: With program enable set, an aligned array write whose size code matches the program size emits one command with kind 0. The command carries the address, a length of 1 << size and the data. The size codes are 0 = byte, 1 = half-word, 2 = word and 3 = double-word. Busy is then high for T_PROG cycles.
- R9: The error flags are operation (status bit 1), write-protection (bit 4), alignment (bit 5), parallelism (bit 6) and sequence (bit 7). Each stays set until a status write has a 1 in that bit. Writing 0 to a flag leaves it set.
- R10: Each of the following sets the sequence error and launches nothing: an array write while locked, an array write with program enable clear, or a start with both sector erase and mass erase set.
- R11: A program write whose size code differs from the program size sets the parallelism error. Otherwise, an address not aligned to the size sets the alignment error. Neither case launches anything.
- R12: A sector erase with a sector number above 11 sets the operation error. An erase or a program that touches a sector marked in PROT_MASK sets the write-protection error. A mass erase touches every sector. Neither case launches anything.
- R13: While busy, control writes and array writes are ignored. They change no field, raise no flag and launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| arr_we | input | 1 | Array data write strobe |
| arr_addr | input | 20 | Array byte address |
| arr_size | input | 2 | Access width code of the array write |
| arr_wdata | input | 64 | Array write data, right-aligned |
| fl_go | output | 1 | One-cycle command strobe to the array |
| fl_kind | output | 2 | 0 program, 1 sector erase, 2 mass erase |
| fl_base | output | 20 | First byte affected |
| fl_len | output | 21 | Number of bytes affected |
| fl_data | output | 64 | Program data |

## Verification
The assertions assume that a register write and an array write never fall in the same cycle. They also assume that register reads have no side effects, so a write is the only way to change state. The bench keeps to these assumptions because one task drives each kind of access at a time, and each access waits for the previous one to finish. Before any further request, the bench polls status until busy has dropped. Random program requests vary program enable, size match, alignment and address. The bench computes the outcome it expects for each, including the error priority order, with its own functions.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
   localparam int ARR_AW = 20;
   localparam int N_SECT = 12;
   localparam logic [7:0] OFF_KEY  = 8'h04;
   localparam logic [7:0] OFF_STAT = 8'h0C;
   localparam logic [7:0] OFF_CTL  = 8'h10;
   localparam int EB_OPE = 1;
   localparam int EB_WRP = 4;
   localparam int EB_ALN = 5;
   localparam int EB_PAR = 6;
   localparam int EB_SEQ = 7;
   localparam logic [7:0] ERR_MASK = 8'hF2;

   typedef enum logic [1:0] {OPK_PROG = 2'd0, OPK_SECT = 2'd1, OPK_MASS = 2'd2} opk_e;

   function automatic logic [ARR_AW-1:0] sect_base(input logic [3:0] s);
      logic [3:0] big;
      big = s - 4'd4;
      if (s < 4'd4)       sect_base = ARR_AW'({s[1:0], 14'h0});
      else if (s == 4'd4) sect_base = ARR_AW'(20'h10000);
      else                sect_base = ARR_AW'({big[2:0], 17'h0});
   endfunction

   function automatic logic [ARR_AW:0] sect_len(input logic [3:0] s);
      if (s < 4'd4)       sect_len = 21'h04000;
      else if (s == 4'd4) sect_len = 21'h10000;
      else                sect_len = 21'h20000;
   endfunction

   function automatic logic [3:0] sect_of(input logic [ARR_AW-1:0] a);
      if (a < 20'h10000)      sect_of = {2'b00, a[15:14]};
      else if (a < 20'h20000) sect_of = 4'd4;
      else                    sect_of = 4'd4 + {1'b0, a[19:17]};
   endfunction
endpackage

// File: rtl/flashctl_keyseq.sv
module flashctl_keyseq #(
   parameter logic [31:0] KEY_A = 32'h45670123,
   parameter logic [31:0] KEY_B = 32'hCDEF89AB
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_we,
   input  logic [31:0] key_val,
   input  logic        relock,
   output logic        unlocked
);
   typedef enum logic [1:0] {KS_WAIT_A, KS_WAIT_B, KS_OPEN, KS_DEAD} ks_e;
   ks_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= KS_WAIT_A;
      else begin
         case (st)
            KS_WAIT_A: if (key_we) st <= (key_val == KEY_A) ? KS_WAIT_B : KS_DEAD;
            KS_WAIT_B: if (key_we) st <= (key_val == KEY_B) ? KS_OPEN : KS_DEAD;
            KS_OPEN:   if (relock) st <= KS_WAIT_A;
            default:   st <= KS_DEAD;
         endcase
      end
   end

   assign unlocked = (st == KS_OPEN);
endmodule

// File: rtl/flashctl_optimer.sv
module flashctl_optimer #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          busy
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/flashctl_errbank.sv
module flashctl_errbank #(
   parameter int           W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] flags
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_flag
         logic f_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (clr[i]) f_q <= 1'b0;
         end
         assign flags[i] = f_q;
      end else begin : g_zero
         assign flags[i] = 1'b0;
      end
   end
endmodule

// File: rtl/flashctl_unit.sv
module flashctl_unit
   import flashctl_pkg::*;
#(
   parameter int          REG_AW    = 8,
   parameter int          T_PROG    = 4,
   parameter int          T_SECT    = 12,
   parameter int          T_MASS    = 24,
   parameter logic [11:0] PROT_MASK = 12'h000,
   parameter logic [31:0] KEY_A     = 32'h45670123,
   parameter logic [31:0] KEY_B     = 32'hCDEF89AB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [REG_AW-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic                arr_we,
   input  logic [ARR_AW-1:0]   arr_addr,
   input  logic [1:0]          arr_size,
   input  logic [63:0]         arr_wdata,
   output logic                fl_go,
   output logic [1:0]          fl_kind,
   output logic [ARR_AW-1:0]   fl_base,
   output logic [ARR_AW:0]     fl_len,
   output logic [63:0]         fl_data
);
   localparam int TMAX_PS = (T_PROG > T_SECT) ? T_PROG : T_SECT;
   localparam int TMAX    = (TMAX_PS > T_MASS) ? TMAX_PS : T_MASS;
   localparam int CW      = $clog2(TMAX + 1);
   localparam logic [15:0] PROT16 = {4'h0, PROT_MASK};

   if (REG_AW < 5) begin : g_bad_aw
      $error("REG_AW too small for register offsets");
   end
   if (T_PROG < 1 || T_SECT < 1 || T_MASS < 1) begin : g_bad_t
      $error("operation durations must be at least one cycle");
   end

   logic       unlocked, busy_w;
   logic       pg_q, ser_q, mer_q;
   logic [3:0] snb_q;
   logic [1:0] psz_q;
   logic [7:0] err_q, err_set, err_clr;

   logic key_we, ctl_we, st_we, relock, start;
   logic [3:0] w_snb;
   logic       launch;
   opk_e       l_kind;
   logic [ARR_AW-1:0] l_base;
   logic [ARR_AW:0]   l_len;
   logic [CW-1:0]     l_dur;
   logic [2:0]        aln_mask;

   assign key_we  = bus_we && (bus_addr == REG_AW'(OFF_KEY));
   assign ctl_we  = bus_we && (bus_addr == REG_AW'(OFF_CTL)) && unlocked && !busy_w;
   assign st_we   = bus_we && (bus_addr == REG_AW'(OFF_STAT));
   assign relock  = ctl_we && bus_wdata[31];
   assign start   = ctl_we && !bus_wdata[31] && bus_wdata[16];
   assign w_snb   = bus_wdata[6:3];
   assign err_clr = st_we ? bus_wdata[7:0] : 8'h00;
   assign aln_mask = 3'((4'd1 << arr_size) - 4'd1);

   flashctl_keyseq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
      .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_val(bus_wdata),
      .relock(relock), .unlocked(unlocked)
   );

   always_comb begin
      err_set = '0;
      launch  = 1'b0;
      l_kind  = OPK_PROG;
      l_base  = '0;
      l_len   = '0;
      l_dur   = '0;
      if (start) begin
         if (bus_wdata[2] && bus_wdata[1]) err_set[EB_SEQ] = 1'b1;
         else if (bus_wdata[2]) begin
            if (PROT_MASK != 12'h000) err_set[EB_WRP] = 1'b1;
            else begin
               launch = 1'b1;
               l_kind = OPK_MASS;
               l_len  = 21'h100000;
               l_dur  = CW'(T_MASS);
            end
         end else if (bus_wdata[1]) begin
            if (w_snb >= 4'(N_SECT)) err_set[EB_OPE] = 1'b1;
            else if (PROT16[w_snb]) err_set[EB_WRP] = 1'b1;
            else begin
               launch = 1'b1;
               l_kind = OPK_SECT;
               l_base = sect_base(w_snb);
               l_len  = sect_len(w_snb);
               l_dur  = CW'(T_SECT);
            end
         end
      end else if (arr_we && !busy_w) begin
         if (!unlocked || !pg_q)               err_set[EB_SEQ] = 1'b1;
         else if (arr_size != psz_q)           err_set[EB_PAR] = 1'b1;
         else if (|(arr_addr[2:0] & aln_mask)) err_set[EB_ALN] = 1'b1;
         else if (PROT16[sect_of(arr_addr)])   err_set[EB_WRP] = 1'b1;
         else begin
            launch = 1'b1;
            l_kind = OPK_PROG;
            l_base = arr_addr;
            l_len  = 21'd1 << arr_size;
            l_dur  = CW'(T_PROG);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pg_q  <= 1'b0;
         ser_q <= 1'b0;
         mer_q <= 1'b0;
         snb_q <= '0;
         psz_q <= '0;
      end else if (ctl_we) begin
         pg_q  <= bus_wdata[0];
         ser_q <= bus_wdata[1];
         mer_q <= bus_wdata[2];
         snb_q <= w_snb;
         psz_q <= bus_wdata[9:8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_go   <= 1'b0;
         fl_kind <= OPK_PROG;
         fl_base <= '0;
         fl_len  <= '0;
         fl_data <= '0;
      end else begin
         fl_go <= launch;
         if (launch) begin
            fl_kind <= l_kind;
            fl_base <= l_base;
            fl_len  <= l_len;
            fl_data <= arr_wdata;
         end
      end
   end

   flashctl_optimer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(launch), .load_val(l_dur), .busy(busy_w)
   );

   flashctl_errbank #(.W(8), .MASK(ERR_MASK)) u_err (
      .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .flags(err_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == REG_AW'(OFF_STAT)) begin
         bus_rdata[16]  = busy_w;
         bus_rdata[7:0] = err_q;
      end else if (bus_addr == REG_AW'(OFF_CTL)) begin
         bus_rdata[31]  = !unlocked;
         bus_rdata[0]   = pg_q;
         bus_rdata[1]   = ser_q;
         bus_rdata[2]   = mer_q;
         bus_rdata[6:3] = snb_q;
         bus_rdata[9:8] = psz_q;
      end
   end
endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk
   import flashctl_pkg::*;
#(
   parameter int          REG_AW = 8,
   parameter logic [31:0] KEY_B  = 32'hCDEF89AB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [REG_AW-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              unlocked,
   input logic              busy,
   input logic              fl_go,
   input logic [7:0]        err
);
   AST_OPEN_ON_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(bus_we && bus_addr == REG_AW'(OFF_KEY) && bus_wdata == KEY_B)) // R2
      else $error("unlock without second key");
   AST_GO_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go |-> $past(unlocked)) // R4
      else $error("command while locked");
   AST_GO_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go |-> busy) // R7
      else $error("command without busy");
   AST_NO_GO_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go |-> !$past(busy)) // R13
      else $error("command launched while busy");
   AST_SEQ_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err[EB_SEQ]) |-> $past(bus_we && bus_addr == REG_AW'(OFF_STAT) && bus_wdata[EB_SEQ])) // R9
      else $error("sequence flag dropped without clear");
   AST_OPE_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err[EB_OPE]) |-> $past(bus_we && bus_addr == REG_AW'(OFF_STAT) && bus_wdata[EB_OPE])) // R9
      else $error("operation flag dropped without clear");
endmodule

bind flashctl_unit flashctl_chk #(.REG_AW(REG_AW), .KEY_B(KEY_B)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .unlocked(unlocked), .busy(busy_w),
   .fl_go(fl_go), .err(err_q)
);

// File: tb/flashctl_unit_test.sv
module flashctl_unit_test;
   localparam int TP = 3, TS = 7, TM = 11;
   localparam logic [7:0] A_KEY = 8'h04, A_STAT = 8'h0C, A_CTL = 8'h10;
   localparam logic [31:0] K1 = 32'h45670123, K2 = 32'hCDEF89AB;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        bus_we = 1'b0, arr_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, wp_rdata;
   logic [19:0] arr_addr = '0;
   logic [1:0]  arr_size = '0;
   logic [63:0] arr_wdata = '0;
   logic        fl_go, wp_go;
   logic [1:0]  fl_kind, wp_kind;
   logic [19:0] fl_base, wp_base;
   logic [20:0] fl_len, wp_len;
   logic [63:0] fl_data, wp_data;

   flashctl_unit #(.T_PROG(TP), .T_SECT(TS), .T_MASS(TM)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_size(arr_size), .arr_wdata(arr_wdata),
      .fl_go(fl_go), .fl_kind(fl_kind), .fl_base(fl_base), .fl_len(fl_len),
      .fl_data(fl_data));

   flashctl_unit #(.T_PROG(TP), .T_SECT(TS), .T_MASS(TM), .PROT_MASK(12'h800)) uut_wp (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(wp_rdata), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_size(arr_size), .arr_wdata(arr_wdata),
      .fl_go(wp_go), .fl_kind(wp_kind), .fl_base(wp_base), .fl_len(wp_len),
      .fl_data(wp_data));

   int n_chk = 0, n_fail = 0;
   int op_n = 0;
   logic [1:0]  op_k;
   logic [19:0] op_b;
   logic [20:0] op_l;
   logic [63:0] op_d;

   always @(posedge clk) if (fl_go) begin
      op_n++;
      op_k = fl_kind; op_b = fl_base; op_l = fl_len; op_d = fl_data;
   end

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic awr(logic [19:0] a, logic [1:0] s, logic [63:0] d);
      @(negedge clk); arr_we = 1'b1; arr_addr = a; arr_size = s; arr_wdata = d;
      @(negedge clk); arr_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, bit wp, output logic [31:0] v);
      bus_addr = a; #1;
      v = wp ? wp_rdata : bus_rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [31:0] v;
      cyc = 0;
      forever begin
         rd(A_STAT, 1'b0, v);
         if (!v[16]) break;
         cyc++;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic unlock();
      wr(A_KEY, K1); wr(A_KEY, K2);
   endtask

   function automatic logic [19:0] e_base(int s);
      if (s < 4) return 20'(s * 16384);
      if (s == 4) return 20'h10000;
      return 20'((s - 4) * 131072);
   endfunction

   function automatic logic [20:0] e_len(int s);
      if (s < 4) return 21'd16384;
      if (s == 4) return 21'd65536;
      return 21'd131072;
   endfunction

   function automatic logic [7:0] e_prog_err(bit pg, logic [1:0] psz, logic [1:0] sz, logic [19:0] a);
      if (!pg) return 8'h80;
      if (sz != psz) return 8'h40;
      if ((int'(a) % (1 << sz)) != 0) return 8'h20;
      return 8'h00;
   endfunction

   task automatic report();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int c, n0;
      int sl[5] = '{0, 3, 4, 5, 11};
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(A_CTL, 0, v);  check("R1 ctrl reset", v, 32'h8000_0000);
      rd(A_STAT, 0, v); check("R1 status reset", v, 32'h0);

      wr(A_CTL, 32'h0000_0201);
      rd(A_CTL, 0, v);  check("R4 locked ctrl write ignored", v, 32'h8000_0000);

      unlock();
      rd(A_CTL, 0, v);  check("R2 unlocked", v, 32'h0);

      wr(A_CTL, 32'h0001_022B - 32'h0001_0000);
      rd(A_CTL, 0, v);  check("R5 field readback", v, 32'h0000_022B);
      wr(A_CTL, 32'h0);

      foreach (sl[i]) begin
         n0 = op_n;
         wr(A_CTL, 32'h0001_0002 | (32'(sl[i]) << 3));
         wait_idle(c);
         check("R6 erase busy cycles", 64'(c), 64'(TS));
         check("R6 one command", 64'(op_n), 64'(n0 + 1));
         check("R6 kind", 64'(op_k), 64'd1);
         check("R6 base", 64'(op_b), 64'(e_base(sl[i])));
         check("R6 length", 64'(op_l), 64'(e_len(sl[i])));
         rd(A_STAT, 1, v);
         check("R12 protected sector", 64'(v[7:0]), (sl[i] == 11) ? 64'h10 : 64'h0);
         wr(A_STAT, 32'hFF);
      end

      n0 = op_n;
      wr(A_CTL, 32'h0001_0004);
      wait_idle(c);
      check("R7 mass busy cycles", 64'(c), 64'(TM));
      check("R7 kind", 64'(op_k), 64'd2);
      check("R7 base", 64'(op_b), 64'd0);
      check("R7 length", 64'(op_l), 64'h100000);
      check("R7 one command", 64'(op_n), 64'(n0 + 1));
      rd(A_STAT, 1, v); check("R12 mass erase protected", 64'(v[7:0]), 64'h10);
      wr(A_STAT, 32'hFF);

      n0 = op_n;
      wr(A_CTL, 32'h0001_0002 | (32'd13 << 3));
      rd(A_STAT, 0, v); check("R12 bad sector number", v, 32'h0000_0002);
      check("R12 no command", 64'(op_n), 64'(n0));
      wr(A_STAT, 32'h00);
      rd(A_STAT, 0, v); check("R9 write 0 keeps flag", v, 32'h2);
      wr(A_STAT, 32'hFD);
      rd(A_STAT, 0, v); check("R9 other ones keep flag", v, 32'h2);
      wr(A_STAT, 32'h02);
      rd(A_STAT, 0, v); check("R9 write 1 clears", v, 32'h0);

      wr(A_CTL, 32'h0001_0006);
      rd(A_STAT, 0, v); check("R10 both erase kinds", v, 32'h80);
      wr(A_STAT, 32'hFF);

      n0 = op_n;
      wr(A_CTL, 32'h0001_0004);
      wr(A_CTL, 32'h0000_0001);
      awr(20'h0, 2'd0, 64'h0);
      wait_idle(c);
      rd(A_CTL, 0, v);  check("R13 ctrl unchanged while busy", v, 32'h4);
      rd(A_STAT, 0, v); check("R13 no flag while busy", v, 32'h0);
      check("R13 single command", 64'(op_n), 64'(n0 + 1));

      wr(A_CTL, 32'h0000_0301);
      n0 = op_n;
      awr(20'h08010, 2'd3, 64'h0123_4567_89AB_CDEF);
      wait_idle(c);
      check("R8 program busy cycles", 64'(c), 64'(TP));
      check("R8 kind", 64'(op_k), 64'd0);
      check("R8 base", 64'(op_b), 64'h08010);
      check("R8 length", 64'(op_l), 64'd8);
      check("R8 data", op_d, 64'h0123_4567_89AB_CDEF);
      check("R8 one command", 64'(op_n), 64'(n0 + 1));

      wr(A_CTL, 32'h0000_0101);
      awr(20'hF0000, 2'd1, 64'h5A5A);
      wait_idle(c);
      rd(A_STAT, 1, v); check("R12 program protected", 64'(v[7:0]), 64'h10);
      check("R8 unprotected programs", 64'(op_b), 64'hF0000);
      wr(A_STAT, 32'hFF);

      for (int it = 0; it < 48; it++) begin
         bit pg;
         logic [1:0] psz, sz;
         logic [19:0] a;
         logic [63:0] d;
         logic [7:0] ee;
         pg  = ($urandom % 4) != 0;
         psz = 2'($urandom);
         sz  = (($urandom % 3) == 0) ? 2'($urandom) : psz;
         a   = 20'($urandom);
         if ($urandom % 2) a = a & ~20'(7);
         d   = {$urandom, $urandom};
         ee  = e_prog_err(pg, psz, sz, a);
         wr(A_CTL, {22'h0, psz, 7'h0, pg});
         n0 = op_n;
         awr(a, sz, d);
         wait_idle(c);
         rd(A_STAT, 0, v);
         check("R11 random error flags", 64'(v[7:0]), 64'(ee));
         if (ee == 8'h0) begin
            check("R8 random base", 64'(op_b), 64'(a));
            check("R8 random length", 64'(op_l), 64'(21'd1 << sz));
            check("R8 random data", op_d, d);
         end else begin
            check("R10 no command on error", 64'(op_n), 64'(n0));
         end
         wr(A_STAT, 32'hFF);
      end

      wr(A_CTL, 32'h8000_0000);
      rd(A_CTL, 0, v);  check("R4 relocked", v, 32'h8000_0000);
      awr(20'h0, 2'd0, 64'h0);
      rd(A_STAT, 0, v); check("R10 array write while locked", v, 32'h80);
      wr(A_STAT, 32'hFF);
      unlock();
      rd(A_CTL, 0, v);  check("R4 keys again unlock", v, 32'h0);

      wr(A_CTL, 32'h8000_0000);
      wr(A_KEY, K2);
      wr(A_KEY, K1);
      wr(A_KEY, K2);
      rd(A_CTL, 0, v);  check("R3 wrong order stays locked", v, 32'h8000_0000);
      unlock();
      rd(A_CTL, 0, v);  check("R3 later keys ignored", v, 32'h8000_0000);

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      unlock();
      rd(A_CTL, 0, v);  check("R3 reset restores unlock", v, 32'h0);

      report();
      $finish;
   end
endmodule